// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is a single timer channel. A free-running up counter is paired with two general registers, A and B. Each register has its own 3-bit mode code in a shared 8-bit control register. The code makes the register either an output-compare register or an input-capture register.

In compare mode, equality between the counter and the register can drive the register's output pin low, drive it high, or toggle it. In capture mode, a chosen edge on the register's input pin copies the counter into the register.

A parameter marks one instance as the special channel. On that instance the toggle code drives the pin high instead of toggling it. Software reaches everything through a small word-wide register port. Writes take effect on the next clock edge, and reads are combinational from the address.

Top module: `tcc_channel`

## Requirements
- R1: Address 0 holds the mode codes: register A in bits 2:0 and register B in bits 6:4. Bits 7 and 3 always read 1 and ignore writes, so the reset value reads 0x88.
- R2: Address 1 reads the counter, which is 0 under reset and adds one on every clock edge, wrapping at the top. Writes to address 1 are ignored. Registers A (address 2) and B (address 3) reset to all ones, and unused addresses 5 to 7 read 0.
- R3: Code 000 is compare mode with the pin untouched. A match (counter equal to the register value before a clock edge) only sets the register's flag.
- R4: Code 001 drives the register's pin low on a match, and code 010 drives it high on a match.
- R5: Code 011 toggles the pin on each match. On an instance built as the special channel it drives the pin high instead.
- R6: Code 100 captures on a rising pin edge and code 101 on a falling edge. The pin passes two synchronising flops and is compared with one more delayed sample. The capture happens on the third clock edge after the pin changes and stores the counter value held just before that edge.
- R7: Codes 110 and 111 capture on both edges of the pin.
- R8: Address 4 holds the flags: bit 0 for A and bit 1 for B. A flag is set by a match or a capture. Writing 0 to a flag bit clears it and writing 1 leaves it. A set in the same cycle as a clear wins.
- R9: Software may write register A or B in any mode. A capture in the same cycle takes priority over the write.
- R10: Both pins reset low. A pin changes only on a compare match, so it keeps its value in the disabled code and in capture modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr |
| pin_in | input | 2 | Capture pins, bit 0 for A, bit 1 for B |
| pin_out | output | 2 | Compare pins, bit 0 for A, bit 1 for B |

## Verification
A capture can land in the same clock edge as a software write to the same general register. A compare match can also land in the same cycle as a software clear of its flag. The bench provokes the first case directly: it raises a capture pin and issues the write two edges later, so both reach the third edge together. Random traffic hits both cases repeatedly. The register must then read the counter value captured, not the written data, and the flag must stay set. The bench counts how many collisions occurred and fails if there were none.

// File: rtl/tcc_pkg.sv
`timescale 1ns/1ps
package tcc_pkg;

   typedef logic [2:0] io_code_t;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_LOW    = 2'd1,
      ACT_HIGH   = 2'd2,
      ACT_TOGGLE = 2'd3
   } cmp_act_t;

   typedef struct packed {
      logic     capture;
      logic     on_rise;
      logic     on_fall;
      cmp_act_t act;
   } gr_mode_t;

   localparam int unsigned CTL_ADDR  = 0;
   localparam int unsigned CNT_ADDR  = 1;
   localparam int unsigned GRA_ADDR  = 2;
   localparam int unsigned FLAG_ADDR = 4;
   localparam int unsigned FIELD_STRIDE = 4;
   localparam int unsigned FIELD_W = 3;

   // Decode a 3-bit mode code; 011 decodes to toggle here, the special
   // channel variant is chosen later by a generate block.
   function automatic gr_mode_t decode_code(input io_code_t c);
      gr_mode_t m;
      m.capture = c[2];
      m.on_rise = c[2] & (c[1] | ~c[0]);
      m.on_fall = c[2] & (c[1] |  c[0]);
      if (c[2]) m.act = ACT_NONE;
      else begin
         case (c[1:0])
            2'b00:   m.act = ACT_NONE;
            2'b01:   m.act = ACT_LOW;
            2'b10:   m.act = ACT_HIGH;
            default: m.act = ACT_TOGGLE;
         endcase
      end
      return m;
   endfunction

endpackage

// File: rtl/tcc_edge_sync.sv
`timescale 1ns/1ps
module tcc_edge_sync #(
   parameter int unsigned STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tcc_edge_sync: STAGES must be at least 2");
   end

   // sh_q[STAGES-1] is the synchronised sample, sh_q[STAGES] the one before
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], pin};
   end

   assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
   assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/tcc_gen_reg.sv
`timescale 1ns/1ps
module tcc_gen_reg
   import tcc_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter bit          SPECIAL = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  io_code_t         code,
   input  logic [CNT_W-1:0] cnt,
   input  logic             sw_wr,
   input  logic [CNT_W-1:0] sw_data,
   input  logic             flag_clr,
   input  logic             rise,
   input  logic             fall,
   output logic [CNT_W-1:0] value,
   output logic             pin,
   output logic             flag,
   output logic             match,
   output logic             cap_ev
);
   gr_mode_t mode_raw;
   cmp_act_t act;
   logic [CNT_W-1:0] val_q;
   logic             pin_q;
   logic             flag_q;

   assign mode_raw = decode_code(code);

   if (SPECIAL) begin : g_special
      assign act = (mode_raw.act == ACT_TOGGLE) ? ACT_HIGH : mode_raw.act;
   end else begin : g_normal
      assign act = mode_raw.act;
   end

   assign match  = !mode_raw.capture && (cnt == val_q);
   assign cap_ev = (mode_raw.on_rise & rise) | (mode_raw.on_fall & fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= '1;
      else if (cap_ev) val_q <= cnt;
      else if (sw_wr)  val_q <= sw_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else if (match) begin
         case (act)
            ACT_LOW:    pin_q <= 1'b0;
            ACT_HIGH:   pin_q <= 1'b1;
            ACT_TOGGLE: pin_q <= ~pin_q;
            default:    pin_q <= pin_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag_q <= 1'b0;
      else if (match || cap_ev)  flag_q <= 1'b1;
      else if (flag_clr)         flag_q <= 1'b0;
   end

   assign value = val_q;
   assign pin   = pin_q;
   assign flag  = flag_q;
endmodule

// File: rtl/tcc_channel.sv
`timescale 1ns/1ps
module tcc_channel
   import tcc_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SPECIAL_CH  = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic [1:0]        pin_in,
   output logic [1:0]        pin_out
);
   localparam int unsigned NUM_GR = 2;
   localparam int unsigned CTL_W  = FIELD_STRIDE * NUM_GR;

   if (CNT_W < CTL_W) begin : g_bad_width
      $error("tcc_channel: CNT_W must hold the control register");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("tcc_channel: ADDR_W must be at least 3");
   end

   logic [CNT_W-1:0]              cnt_q;
   logic [NUM_GR-1:0][2:0]        code_q;
   logic [NUM_GR-1:0][CNT_W-1:0]  gval;
   logic [NUM_GR-1:0]             flag, match, cap_ev, rise, fall;
   logic [NUM_GR-1:0]             sw_wr, flag_clr;
   logic [CTL_W-1:0]              ctl_view;
   logic                          ctl_wr, flag_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign ctl_wr  = bus_wr && (bus_addr == ADDR_W'(CTL_ADDR));
   assign flag_wr = bus_wr && (bus_addr == ADDR_W'(FLAG_ADDR));

   for (genvar gi = 0; gi < NUM_GR; gi++) begin : g_gr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      code_q[gi] <= '0;
         else if (ctl_wr) code_q[gi] <= bus_wdata[FIELD_STRIDE*gi +: FIELD_W];
      end

      assign sw_wr[gi]    = bus_wr && (bus_addr == ADDR_W'(GRA_ADDR + gi));
      assign flag_clr[gi] = flag_wr && !bus_wdata[gi];
      assign ctl_view[FIELD_STRIDE*gi +: FIELD_STRIDE] = {1'b1, code_q[gi]};

      tcc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .pin  (pin_in[gi]),
         .rise (rise[gi]),
         .fall (fall[gi])
      );

      tcc_gen_reg #(.CNT_W(CNT_W), .SPECIAL(SPECIAL_CH)) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .code    (code_q[gi]),
         .cnt     (cnt_q),
         .sw_wr   (sw_wr[gi]),
         .sw_data (bus_wdata),
         .flag_clr(flag_clr[gi]),
         .rise    (rise[gi]),
         .fall    (fall[gi]),
         .value   (gval[gi]),
         .pin     (pin_out[gi]),
         .flag    (flag[gi]),
         .match   (match[gi]),
         .cap_ev  (cap_ev[gi])
      );
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(CTL_ADDR):     bus_rdata = CNT_W'(ctl_view);
         ADDR_W'(CNT_ADDR):     bus_rdata = cnt_q;
         ADDR_W'(GRA_ADDR):     bus_rdata = gval[0];
         ADDR_W'(GRA_ADDR + 1): bus_rdata = gval[1];
         ADDR_W'(FLAG_ADDR):    bus_rdata = CNT_W'(flag);
         default:               bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tcc_channel_chk.sv
`timescale 1ns/1ps
module tcc_channel_chk #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 3
)(
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_wr,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [CNT_W-1:0]       bus_wdata,
   input logic [1:0]             pin_out,
   input logic [CNT_W-1:0]       cnt,
   input logic [1:0][2:0]        code,
   input logic [1:0][CNT_W-1:0]  gval,
   input logic [1:0]             match,
   input logic [1:0]             cap_ev,
   input logic [1:0]             flag
);
   AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == '0) |=> (code[0] == $past(bus_wdata[2:0]) && code[1] == $past(bus_wdata[6:4]))); // R1
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2
   AST_PIN_LOW_A: assert property (@(posedge clk) disable iff (!rst_n)
      (match[0] && code[0] == 3'b001) |=> !pin_out[0]); // R4
   AST_PIN_HIGH_B: assert property (@(posedge clk) disable iff (!rst_n)
      (match[1] && code[1] == 3'b010) |=> pin_out[1]); // R4
   AST_CAP_MODE_A: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ev[0] |-> code[0][2]); // R6
   AST_CAP_WINS_A: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ev[0] |=> gval[0] == $past(cnt)); // R9
   AST_CAP_WINS_B: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ev[1] |=> gval[1] == $past(cnt)); // R9
   AST_FLAG_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
      (match[0] || cap_ev[0]) |=> flag[0]); // R8
   AST_FLAG_SET_B: assert property (@(posedge clk) disable iff (!rst_n)
      (match[1] || cap_ev[1]) |=> flag[1]); // R8
   AST_PIN_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
      !match[0] |=> $stable(pin_out[0])); // R10
   AST_PIN_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
      !match[1] |=> $stable(pin_out[1])); // R10
endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .pin_out  (pin_out),
   .cnt      (cnt_q),
   .code     (code_q),
   .gval     (gval),
   .match    (match),
   .cap_ev   (cap_ev),
   .flag     (flag)
);

// File: tb/sim_tcc_channel.sv
`timescale 1ns/1ps
module sim_tcc_channel;
   localparam int CW = 16;
   localparam time PERIOD = 20ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic [CW-1:0] bus_wdata = '0;
   logic [1:0]    pin_in = '0;
   logic [CW-1:0] rd0, rd1;
   logic [1:0]    po0, po1;

   int checks = 0;
   int fails = 0;
   int collisions = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   tcc_channel #(.CNT_W(CW), .SPECIAL_CH(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd0), .pin_in(pin_in), .pin_out(po0));

   tcc_channel #(.CNT_W(CW), .SPECIAL_CH(1'b1)) u_spec (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd1), .pin_in(pin_in), .pin_out(po1));

   // Reference state built from the requirements
   logic [CW-1:0] m_cnt;
   logic [2:0]    m_code [2];
   logic [CW-1:0] m_g    [2];
   logic          m_flag [2];
   logic          m_pin  [2][2];   // [instance][register]
   logic [1:0]    m_s1, m_s2, m_pv;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = '0;
         m_s1 = '0; m_s2 = '0; m_pv = '0;
         for (int i = 0; i < 2; i++) begin
            m_code[i] = '0; m_g[i] = '1; m_flag[i] = 1'b0;
            m_pin[0][i] = 1'b0; m_pin[1][i] = 1'b0;
         end
      end else begin
         for (int i = 0; i < 2; i++) begin
            logic er, ef, cap, mt, wr_g;
            er   = m_s2[i] & ~m_pv[i];
            ef   = ~m_s2[i] & m_pv[i];
            cap  = m_code[i][2] && (m_code[i][1] ? (er | ef) : (m_code[i][0] ? ef : er));
            mt   = !m_code[i][2] && (m_cnt == m_g[i]);
            wr_g = bus_wr && (bus_addr == 3'(2 + i));
            if (cap && wr_g) collisions++;
            if (cap) m_g[i] = m_cnt;
            else if (wr_g) m_g[i] = bus_wdata;
            if (mt) begin
               for (int k = 0; k < 2; k++) begin
                  case (m_code[i][1:0])
                     2'b01: m_pin[k][i] = 1'b0;
                     2'b10: m_pin[k][i] = 1'b1;
                     2'b11: m_pin[k][i] = (k == 1) ? 1'b1 : ~m_pin[k][i];
                     default: ;
                  endcase
               end
            end
            if (mt || cap) m_flag[i] = 1'b1;
            else if (bus_wr && bus_addr == 3'd4 && !bus_wdata[i]) m_flag[i] = 1'b0;
         end
         if (bus_wr && bus_addr == 3'd0) begin
            m_code[0] = bus_wdata[2:0];
            m_code[1] = bus_wdata[6:4];
         end
         m_cnt = m_cnt + 1'b1;
         m_pv = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      end
   end

   function automatic logic [CW-1:0] mread(input logic [2:0] a);
      case (a)
         3'd0: return CW'({1'b1, m_code[1], 1'b1, m_code[0]});
         3'd1: return m_cnt;
         3'd2: return m_g[0];
         3'd3: return m_g[1];
         3'd4: return CW'({m_flag[1], m_flag[0]});
         default: return '0;
      endcase
   endfunction

   function automatic string addr_tag(input logic [2:0] a);
      case (a)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2, 3'd3: return "R6";
         3'd4: return "R8";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [CW-1:0] act, input logic [CW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string tag);
      string rt, pt;
      logic [CW-1:0] e;
      rt = (tag == "") ? addr_tag(bus_addr) : tag;
      pt = (tag == "") ? "R4" : tag;
      e = mread(bus_addr);
      chk(rd0 == e, rt, "read u0", rd0, e);
      chk(rd1 == e, rt, "read u_spec", rd1, e);
      chk(po0 == {m_pin[0][1], m_pin[0][0]}, pt, "pins u0", CW'(po0),
          CW'({m_pin[0][1], m_pin[0][0]}));
      chk(po1 == {m_pin[1][1], m_pin[1][0]}, pt, "pins u_spec", CW'(po1),
          CW'({m_pin[1][1], m_pin[1][0]}));
   endtask

   task automatic step(input logic wr, input logic [2:0] a, input logic [CW-1:0] d,
                       input logic [1:0] p, input string tag);
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d; pin_in = p;
      #1;
      compare_all(tag);
   endtask

   task automatic idle(input int n, input logic [2:0] a, input logic [1:0] p, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, a, '0, p, tag);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      // Reset state
      repeat (3) @(negedge clk);
      bus_addr = 3'd0; #1;
      chk(rd0 == 16'h0088, "R1", "reset ctl", rd0, 16'h0088);
      chk(po0 == 2'b00 && po1 == 2'b00, "R10", "reset pins", CW'({po1, po0}), '0);
      bus_addr = 3'd2; #1;
      chk(rd0 == 16'hffff, "R2", "reset reg A", rd0, 16'hffff);
      @(negedge clk); rst_n = 1'b1;

      // R1: reserved bits ignore writes
      step(1'b1, 3'd0, 16'h0000, 2'b00, "R1");
      idle(1, 3'd0, 2'b00, "R1");
      step(1'b1, 3'd1, 16'h5555, 2'b00, "R2");
      idle(2, 3'd1, 2'b00, "R2");

      // R3: disabled compare only sets flag
      step(1'b1, 3'd2, m_cnt + 16'd3, 2'b00, "R3");
      idle(5, 3'd4, 2'b00, "R3");

      // R4: low on A, high on B
      step(1'b1, 3'd0, 16'h0021, 2'b00, "R4");
      step(1'b1, 3'd2, m_cnt + 16'd3, 2'b00, "R4");
      step(1'b1, 3'd3, m_cnt + 16'd3, 2'b00, "R4");
      idle(5, 3'd4, 2'b00, "R4");

      // R5: toggle versus special channel
      step(1'b1, 3'd0, 16'h0033, 2'b00, "R5");
      for (int r = 0; r < 3; r++) begin
         step(1'b1, 3'd2, m_cnt + 16'd3, 2'b00, "R5");
         step(1'b1, 3'd3, m_cnt + 16'd3, 2'b00, "R5");
         idle(5, 3'd4, 2'b00, "R5");
      end

      // R10: capture and disabled modes hold the pins
      step(1'b1, 3'd0, 16'h0044, 2'b00, "R10");
      idle(4, 3'd1, 2'b00, "R10");
      step(1'b1, 3'd0, 16'h0000, 2'b00, "R10");
      step(1'b1, 3'd2, m_cnt + 16'd3, 2'b00, "R10");
      idle(5, 3'd0, 2'b00, "R10");

      // R6: rising on A, falling on B
      step(1'b1, 3'd0, 16'h0054, 2'b00, "R6");
      idle(4, 3'd2, 2'b01, "R6");
      idle(4, 3'd3, 2'b11, "R6");
      idle(4, 3'd2, 2'b00, "R6");
      idle(4, 3'd3, 2'b10, "R6");
      idle(4, 3'd3, 2'b00, "R6");

      // R7: both edges
      step(1'b1, 3'd0, 16'h0076, 2'b00, "R7");
      idle(4, 3'd2, 2'b11, "R7");
      idle(4, 3'd3, 2'b00, "R7");
      idle(4, 3'd2, 2'b01, "R7");

      // R9: capture and software write on the same edge
      step(1'b1, 3'd0, 16'h0044, 2'b00, "R9");
      idle(4, 3'd2, 2'b00, "R9");
      step(1'b0, 3'd2, '0, 2'b01, "R9");
      step(1'b0, 3'd2, '0, 2'b01, "R9");
      step(1'b1, 3'd2, 16'h1234, 2'b01, "R9");
      idle(2, 3'd2, 2'b01, "R9");

      // R8: write-zero-to-clear
      step(1'b1, 3'd4, 16'h0002, 2'b01, "R8");
      idle(1, 3'd4, 2'b01, "R8");
      step(1'b1, 3'd4, 16'h0000, 2'b01, "R8");
      idle(1, 3'd4, 2'b01, "R8");

      // Random traffic
      void'($urandom(32'h5eed_1234));
      begin
         logic [1:0] p;
         p = 2'b01;
         for (int n = 0; n < 4000; n++) begin
            int sel;
            logic [2:0] a;
            sel = int'($urandom % 16);
            a = 3'($urandom % 8);
            if ($urandom % 4 == 0) p = p ^ 2'($urandom % 4);
            if (sel == 0)
               step(1'b1, 3'd0, CW'($urandom % 256), p, "");
            else if (sel < 4)
               step(1'b1, 3'(2 + sel % 2), m_cnt + CW'($urandom % 6), p, "");
            else if (sel == 4)
               step(1'b1, 3'd4, CW'($urandom % 4), p, "");
            else if (sel == 5)
               step(1'b1, 3'd1, CW'($urandom), p, "");
            else
               step(1'b0, a, '0, p, "");
         end
      end

      chk(collisions > 0, "R9", "collisions seen", CW'(collisions), 16'd1);
      done = 1'b1;
      finish_run();
   end
endmodule